// File: doc/BRIEF.md
# Serial Byte Receiver with Request-to-Send Throttling

This block turns an asynchronous serial line into bytes for on-chip logic. The line is synchronised, oversampled and framed as one start bit, eight data bits (least significant first), no parity and one stop bit. Each finished byte lands in a single holding register, with no queue behind it. The consumer sees the byte with a valid flag and takes it with a one-cycle read strobe.

Because there is only one slot, the block throttles the far-end sender through an active-low request-to-send output. The output is low while the slot is empty. It goes high as soon as a byte is stored and stays high until that byte is read, so a consumer that reads late stretches the high period. A stop bit sampled low marks the stored byte with a framing error. A frame that finishes while the slot is still occupied is dropped and sets a sticky overrun flag. The clocks per oversample tick is a parameter. At 100 MHz a value of 54 gives about 115200 baud, and a value of 2 gives about 3 Mbaud.

Top module: `uart_rx_rts`

## Requirements
- R1: After reset nrts_o is 0, valid_o is 0, frame_err_o is 0 and overrun_o is 0.
- R2: A frame uses one bit time of CLKS_PER_TICK*OVERSAMPLE clocks per bit: a low start bit, 8 data bits with bit 0 first, then a stop bit. The byte is on data_o with valid_o=1 before the stop bit ends.
- R3: A low pulse on rx_i that is shorter than half a bit time is rejected, and no byte is produced.
- R4: In the clock cycle that a byte enters an empty holding register, nrts_o goes to 1.
- R5: nrts_o stays 1 for as long as no read strobe arrives, however long that is.
- R6: A one-cycle rd_i while valid_o=1 clears valid_o and frame_err_o and returns nrts_o to 0 on the next clock.
- R7: If a frame completes while the register is full and rd_i is low in that cycle, data_o keeps the old byte and overrun_o becomes 1. overrun_o stays 1 until reset, and later reads do not clear it.
- R8: A stop bit sampled low still delivers the byte, with frame_err_o=1 alongside it. A stop bit sampled high gives frame_err_o=0.
- R9: After a low stop bit, the receiver waits for rx_i to return high before it looks for a new start bit. A long low level therefore yields exactly one byte.
- R10: If rd_i and a frame completion fall in the same cycle, the new byte is stored, valid_o and nrts_o stay 1, and overrun_o is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Asynchronous serial receive line, idle high |
| rd_i | input | 1 | One-cycle read strobe from the consumer |
| data_o | output | DATA_W | Holding register contents |
| valid_o | output | 1 | Holding register full |
| nrts_o | output | 1 | Request to send, active low: 0 = send allowed, 1 = hold off |
| frame_err_o | output | 1 | The held byte had a low stop bit |
| overrun_o | output | 1 | Sticky flag: a byte was lost because the register was full |

## Verification
A consumer read and the storing of a newly finished frame can happen in the same clock cycle. The bench first runs a calibration trial with an empty register and records the cycle, counted from the start of the stop bit, in which valid_o rises. Timing after reset is fully deterministic, so the bench then repeats the same stimulus with the register already full. In these repeats it places the read strobe one cycle before, exactly at, and one cycle after that recorded cycle. A read before or in the same cycle must leave the new byte held with no overrun. A read one cycle late must show the overrun flag with the old byte kept.

// File: rtl/uart_rx_rts_pkg.sv
package uart_rx_rts_pkg;

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_STOP,
      RX_BREAK
   } rx_state_e;

   function automatic int unsigned at_least_one(input int unsigned v);
      return (v < 1) ? 1 : v;
   endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic sync_o
);
   logic [STAGES-1:0] chain;

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b1;
               else        chain[0] <= async_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[g] <= 1'b1;
               else        chain[g] <= chain[g-1];
            end
         end
      end
   endgenerate

   assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_tick.sv
module uart_rx_tick #(
   parameter int unsigned DIV = 54
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);
   localparam int unsigned CW   = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(DIV - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (cnt == LAST) cnt <= '0;
      else                  cnt <= cnt + 1'b1;
   end

   assign tick_o = (cnt == LAST);
endmodule

// File: rtl/uart_rx_framer.sv
module uart_rx_framer
   import uart_rx_rts_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned OSR    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              rx_i,
   output logic              done_o,
   output logic [DATA_W-1:0] byte_o,
   output logic              stop_ok_o
);
   localparam int unsigned TW = at_least_one($clog2(OSR));
   localparam int unsigned IW = at_least_one($clog2(DATA_W));
   localparam logic [TW-1:0] MID_T  = TW'(OSR/2 - 1);
   localparam logic [TW-1:0] FULL_T = TW'(OSR - 1);
   localparam logic [IW-1:0] LAST_B = IW'(DATA_W - 1);

   rx_state_e         state;
   logic [TW-1:0]     tcnt;
   logic [IW-1:0]     bidx;
   logic [DATA_W-1:0] shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= RX_IDLE;
         tcnt      <= '0;
         bidx      <= '0;
         shreg     <= '0;
         done_o    <= 1'b0;
         byte_o    <= '0;
         stop_ok_o <= 1'b1;
      end else begin
         done_o <= 1'b0;
         if (tick_i) begin
            unique case (state)
               RX_IDLE: begin
                  if (!rx_i) begin
                     state <= RX_START;
                     tcnt  <= '0;
                  end
               end
               RX_START: begin
                  if (tcnt == MID_T) begin
                     tcnt <= '0;
                     bidx <= '0;
                     state <= rx_i ? RX_IDLE : RX_DATA;
                  end else begin
                     tcnt <= tcnt + 1'b1;
                  end
               end
               RX_DATA: begin
                  if (tcnt == FULL_T) begin
                     tcnt  <= '0;
                     shreg <= {rx_i, shreg[DATA_W-1:1]};
                     if (bidx == LAST_B) state <= RX_STOP;
                     else                bidx  <= bidx + 1'b1;
                  end else begin
                     tcnt <= tcnt + 1'b1;
                  end
               end
               RX_STOP: begin
                  if (tcnt == FULL_T) begin
                     tcnt      <= '0;
                     done_o    <= 1'b1;
                     byte_o    <= shreg;
                     stop_ok_o <= rx_i;
                     state     <= rx_i ? RX_IDLE : RX_BREAK;
                  end else begin
                     tcnt <= tcnt + 1'b1;
                  end
               end
               RX_BREAK: begin
                  if (rx_i) state <= RX_IDLE;
               end
               default: state <= RX_IDLE;
            endcase
         end
      end
   end

   // R2: a finished frame is reported for exactly one cycle
   a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R2: completion only ever follows the stop-bit phase
   a_r2_done_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> ($past(state) == RX_STOP));

   // R9: while waiting out a low line no new frame may begin
   a_r9_break_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (state == RX_BREAK && !rx_i) |=> (state == RX_BREAK));
endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [DATA_W-1:0] byte_i,
   input  logic              stop_ok_i,
   input  logic              rd_i,
   output logic [DATA_W-1:0] data_o,
   output logic              valid_o,
   output logic              nrts_o,
   output logic              ferr_o,
   output logic              ovr_o
);
   logic slot_free;
   assign slot_free = !valid_o || rd_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_o  <= '0;
         valid_o <= 1'b0;
         nrts_o  <= 1'b0;
         ferr_o  <= 1'b0;
         ovr_o   <= 1'b0;
      end else if (load_i && slot_free) begin
         data_o  <= byte_i;
         valid_o <= 1'b1;
         nrts_o  <= 1'b1;
         ferr_o  <= !stop_ok_i;
      end else if (load_i) begin
         ovr_o   <= 1'b1;
      end else if (rd_i) begin
         valid_o <= 1'b0;
         nrts_o  <= 1'b0;
         ferr_o  <= 1'b0;
      end
   end

   // R4: a store into an empty slot raises the hold-off request
   a_r4_rts_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && !valid_o) |=> (nrts_o && valid_o));

   // R5: without a read the hold-off request persists
   a_r5_rts_held: assert property (@(posedge clk) disable iff (!rst_n)
      (nrts_o && !rd_i) |=> nrts_o);

   // R6: a read with no simultaneous store empties the slot
   a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && valid_o && !load_i) |=> (!valid_o && !nrts_o && !ferr_o));

   // R7: a completion into a full slot keeps the old byte and flags it
   a_r7_keep_old: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && valid_o && !rd_i) |=> ($stable(data_o) && ovr_o));

   // R7: the loss flag is sticky
   a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_o |=> ovr_o);

   // R10: read and store in one cycle keep the slot full with no loss
   a_r10_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && valid_o && rd_i) |=> (valid_o && nrts_o && $stable(ovr_o)));
endmodule

// File: rtl/uart_rx_rts.sv
module uart_rx_rts #(
   parameter int unsigned CLKS_PER_TICK = 54,
   parameter int unsigned OVERSAMPLE    = 16,
   parameter int unsigned DATA_W        = 8,
   parameter int unsigned SYNC_STAGES   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_i,
   input  logic              rd_i,
   output logic [DATA_W-1:0] data_o,
   output logic              valid_o,
   output logic              nrts_o,
   output logic              frame_err_o,
   output logic              overrun_o
);
   generate
      if (CLKS_PER_TICK < 1) begin : g_bad_div
         $error("CLKS_PER_TICK must be at least 1");
      end
      if (OVERSAMPLE < 4 || (OVERSAMPLE % 2) != 0) begin : g_bad_osr
         $error("OVERSAMPLE must be even and at least 4");
      end
      if (DATA_W < 2) begin : g_bad_width
         $error("DATA_W must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic              rx_s;
   logic              tick;
   logic              done;
   logic [DATA_W-1:0] rx_byte;
   logic              stop_ok;

   uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (rx_i),
      .sync_o  (rx_s)
   );

   uart_rx_tick #(.DIV(CLKS_PER_TICK)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_o (tick)
   );

   uart_rx_framer #(.DATA_W(DATA_W), .OSR(OVERSAMPLE)) u_framer (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick),
      .rx_i      (rx_s),
      .done_o    (done),
      .byte_o    (rx_byte),
      .stop_ok_o (stop_ok)
   );

   uart_rx_hold #(.DATA_W(DATA_W)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (done),
      .byte_i    (rx_byte),
      .stop_ok_i (stop_ok),
      .rd_i      (rd_i),
      .data_o    (data_o),
      .valid_o   (valid_o),
      .nrts_o    (nrts_o),
      .ferr_o    (frame_err_o),
      .ovr_o     (overrun_o)
   );

   // R1: hold-off request is never raised with an empty slot
   a_r1_rts_tracks_slot: assert property (@(posedge clk) disable iff (!rst_n)
      nrts_o == valid_o);
endmodule

// File: tb/sim_uart_rx_rts.sv
`timescale 1ns/1ps
module sim_uart_rx_rts;
   localparam int CPT = 4;
   localparam int OSR = 16;
   localparam int BIT = CPT * OSR;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx = 1'b1;
   logic       rd = 1'b0;
   logic [7:0] data;
   logic       valid, nrts, ferr, ovr;

   int total = 0;
   int bad   = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   uart_rx_rts #(.CLKS_PER_TICK(CPT), .OVERSAMPLE(OSR), .DATA_W(8), .SYNC_STAGES(2)) u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .rx_i        (rx),
      .rd_i        (rd),
      .data_o      (data),
      .valid_o     (valid),
      .nrts_o      (nrts),
      .frame_err_o (ferr),
      .overrun_o   (ovr)
   );

   function automatic logic exp_ferr(input logic stop_lvl);
      return !stop_lvl;
   endfunction

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
      end
   endtask

   task automatic do_reset();
      rd = 1'b0;
      rx = 1'b1;
      rst_n = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic pulse_read();
      rd = 1'b1;
      @(negedge clk);
      rd = 1'b0;
   endtask

   // Drives one frame; a read strobe can be placed at cycle rd_at of the stop bit,
   // and the first cycle of the stop bit at which valid is seen can be recorded.
   task automatic send_frame(input logic [7:0] b, input logic stop_lvl,
                             input int rd_at, input bit measure, output int m);
      m = -1;
      rx = 1'b0;
      repeat (BIT) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         rx = b[i];
         repeat (BIT) @(negedge clk);
      end
      rx = stop_lvl;
      for (int c = 0; c < BIT; c++) begin
         rd = (c == rd_at);
         @(negedge clk);
         if (measure && m < 0 && valid) m = c;
      end
      rd = 1'b0;
   endtask

   task automatic trial(input bit with_a, input int rd_at, output int m);
      int unused_m;
      do_reset();
      repeat (20) @(negedge clk);
      if (with_a) send_frame(8'h5A, 1'b1, -1, 1'b0, unused_m);
      else        repeat (10 * BIT) @(negedge clk);
      send_frame(8'hC3, 1'b1, rd_at, !with_a, m);
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int m;
      int m_cal;
      void'($urandom(32'h1c0ffee));

      // R1 reset state
      do_reset();
      @(negedge clk);
      chk("R1 nrts", nrts, 0);
      chk("R1 valid", valid, 0);
      chk("R1 ferr", ferr, 0);
      chk("R1 ovr", ovr, 0);

      // R2, R4, R5, R6 directed byte
      repeat (10) @(negedge clk);
      send_frame(8'hA5, 1'b1, -1, 1'b0, m);
      repeat (2) @(negedge clk);
      chk("R2 data", data, 8'hA5);
      chk("R2 valid", valid, 1);
      chk("R4 nrts high", nrts, 1);
      chk("R8 ferr clear", ferr, 0);
      repeat (300) @(negedge clk);
      chk("R5 nrts held", nrts, 1);
      pulse_read();
      chk("R6 valid", valid, 0);
      chk("R6 nrts", nrts, 0);

      // R3 short glitch
      rx = 1'b0;
      repeat (BIT / 4) @(negedge clk);
      rx = 1'b1;
      repeat (12 * BIT) @(negedge clk);
      chk("R3 no byte", valid, 0);
      chk("R3 nrts", nrts, 0);

      // R8, R9 low stop bit followed by long low line
      send_frame(8'h3C, 1'b0, -1, 1'b0, m);
      rx = 1'b0;
      repeat (3 * BIT) @(negedge clk);
      rx = 1'b1;
      repeat (4) @(negedge clk);
      chk("R8 data", data, 8'h3C);
      chk("R8 ferr", ferr, exp_ferr(1'b0));
      chk("R8 valid", valid, 1);
      pulse_read();
      chk("R6 ferr cleared", ferr, 0);
      repeat (12 * BIT) @(negedge clk);
      chk("R9 single byte", valid, 0);

      // R7 overrun
      send_frame(8'h11, 1'b1, -1, 1'b0, m);
      send_frame(8'h22, 1'b1, -1, 1'b0, m);
      repeat (4) @(negedge clk);
      chk("R7 old byte", data, 8'h11);
      chk("R7 ovr", ovr, 1);
      chk("R7 valid", valid, 1);
      pulse_read();
      chk("R7 sticky", ovr, 1);
      chk("R6 valid after ovr", valid, 0);
      do_reset();
      @(negedge clk);
      chk("R1 ovr after reset", ovr, 0);

      // Random traffic
      for (int n = 0; n < 40; n++) begin
         logic [7:0] b;
         logic       stop_lvl;
         int         dly;
         b = 8'($urandom);
         stop_lvl = ($urandom % 6) != 0;
         send_frame(b, stop_lvl, -1, 1'b0, m);
         if (!stop_lvl) begin
            rx = 1'b0;
            repeat (10 + ($urandom % 100)) @(negedge clk);
            rx = 1'b1;
         end
         repeat (4) @(negedge clk);
         chk("R2 rand data", data, b);
         chk("R8 rand ferr", ferr, exp_ferr(stop_lvl));
         chk("R4 rand nrts", nrts, 1);
         dly = $urandom % 200;
         repeat (dly) @(negedge clk);
         chk("R5 rand held", nrts, 1);
         pulse_read();
         chk("R6 rand cleared", valid, 0);
         repeat ($urandom % 40) @(negedge clk);
      end
      chk("R7 no rand overrun", ovr, 0);

      // R10 read and store in the same cycle
      trial(1'b0, -1, m_cal);
      chk("R4 calibration seen", (m_cal >= 1) ? 1 : 0, 1);
      if (m_cal >= 1) begin
         trial(1'b1, m_cal - 1, m);
         chk("R10 early data", data, 8'hC3);
         chk("R10 early ovr", ovr, 0);
         trial(1'b1, m_cal, m);
         chk("R10 same data", data, 8'hC3);
         chk("R10 same valid", valid, 1);
         chk("R10 same nrts", nrts, 1);
         chk("R10 same ovr", ovr, 0);
         trial(1'b1, m_cal + 1, m);
         chk("R7 late ovr", ovr, 1);
         chk("R7 late data", data, 8'h5A);
         chk("R7 late valid", valid, 0);
      end

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule